// File: doc/BRIEF.md
# DMA Channel Event Interrupt Aggregator

This block gathers completion and fault events from up to eight DMA channels and merges them into a single interrupt line for the processor. Every channel reports three kinds of event, each as a one-cycle pulse: its current buffer finished, a chained sequence of buffers finished, or the transfer hit an error. Each event sets a sticky bit in a status word. That word uses three byte-wide groups: buffer-done sits in bits 0..7, chain-done in bits 8..15 and error in bits 16..23, with the channel number as the offset inside each group.

Software controls which events may raise the interrupt through a mask word. It never rewrites this word directly. Instead it writes ones to a set-only register to unmask bits, and ones to a clear-only register to mask them again. A channel is usually switched on by unmasking its buffer-done and error bits in a single write. Reading the status word returns the pending events and clears them in the same access. The interrupt output is a register that is high whenever a pending status bit is also unmasked.

Register offsets (byte addresses) are: 0x18 set-mask (write), 0x1C clear-mask (write), 0x20 mask (read), 0x24 status (read, clear on read).

Top module: `dma_evt_irq`

## Requirements
- R1: After reset the mask and status words are zero, `irq` is low and `rdata` is zero.
- R2: A pulse on `evt_btc[x]`, `evt_chn[x]` or `evt_err[x]` sets status bit x, 8+x or 16+x respectively at the next clock edge.
- R3: A write to offset 0x18 sets every mask bit whose `wdata` bit is 1. Bits written as 0 are left unchanged.
- R4: A write to offset 0x1C clears every mask bit whose `wdata` bit is 1. Bits written as 0 are left unchanged.
- R5: A read of offset 0x24 returns the status word and clears it, so a second read with no new event returns zero.
- R6: An event that arrives in the same cycle as a status read is absent from that read's data and present in the next read.
- R7: `irq` is high exactly when some status bit and the same mask bit are both set. It changes at the same clock edge as the status or mask update that causes the change.
- R8: Status bits latch while masked. Unmasking a pending bit raises `irq` at the edge on which the set-mask write takes effect.
- R9: The mask and status words ignore writes to offsets 0x20 and 0x24, and they ignore `wdata` bits 24..31 and bits of channels at or above NUM_CH.
- R10: A read of offset 0x20 returns the mask word. Reads of 0x18 and 0x1C return zero.
- R11: `rdata` carries the selected register in the cycle after `rd_en` and is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| evt_btc | input | NUM_CH | Per-channel buffer-done pulses |
| evt_chn | input | NUM_CH | Per-channel chain-done pulses |
| evt_err | input | NUM_CH | Per-channel error pulses |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Registered interrupt request |

## Verification
A stuck or dropped status bit shows up at the first status read after the event, and also in `irq` as soon as that bit is unmasked. A mask bit that is corrupted appears in the mask read on the next cycle and changes `irq` at the same edge. The riskiest point is a lost event during read-clear, which only the read that follows can reveal. For that reason the bench schedules an event and a status read in the same cycle and then reads a second time.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned GRP_STRIDE = 8;
   localparam int unsigned N_GRP      = 3;
   localparam int unsigned MAX_CH     = 8;

   typedef logic [WORD_W-1:0] word_t;

   localparam logic [7:0] OFF_SETM = 8'h18;
   localparam logic [7:0] OFF_CLRM = 8'h1C;
   localparam logic [7:0] OFF_MASK = 8'h20;
   localparam logic [7:0] OFF_STAT = 8'h24;

   // Bits of the event word that belong to an existing channel
   function automatic word_t valid_bits(int unsigned nch);
      word_t v;
      v = '0;
      for (int unsigned g = 0; g < N_GRP; g++)
         for (int unsigned c = 0; c < nch; c++)
            v[g*GRP_STRIDE + c] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg
   import dmairq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt_btc,
   input  logic [NUM_CH-1:0] evt_chn,
   input  logic [NUM_CH-1:0] evt_err,
   input  logic              clr,
   output word_t             stat_q,
   output word_t             stat_d
);
   logic [N_GRP-1:0][NUM_CH-1:0] evt_grp;
   word_t                        evt_word;

   assign evt_grp = {evt_err, evt_chn, evt_btc};

   always_comb begin
      evt_word = '0;
      for (int unsigned g = 0; g < N_GRP; g++)
         for (int unsigned c = 0; c < NUM_CH; c++)
            evt_word[g*GRP_STRIDE + c] = evt_grp[g][c];
   end

   // New events always win over the read-clear
   assign stat_d = (clr ? '0 : stat_q) | evt_word;

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
   import dmairq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  set_en,
   input  logic  clr_en,
   input  word_t wdata,
   output word_t mask_q,
   output word_t mask_d
);
   localparam word_t VALID = valid_bits(NUM_CH);

   word_t set_bits, clr_bits;

   assign set_bits = set_en ? (wdata & VALID) : '0;
   assign clr_bits = clr_en ? (wdata & VALID) : '0;
   assign mask_d   = (mask_q | set_bits) & ~clr_bits;

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end
endmodule

// File: rtl/irq_read_out.sv
module irq_read_out
   import dmairq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  rd_mask,
   input  logic  rd_stat,
   input  word_t mask_q,
   input  word_t stat_q,
   input  word_t mask_d,
   input  word_t stat_d,
   output word_t rdata,
   output logic  irq
);
   word_t rsel;

   always_comb begin
      rsel = '0;
      if (rd_mask) rsel = mask_q;
      if (rd_stat) rsel = stat_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         irq   <= 1'b0;
      end else begin
         rdata <= rsel;
         irq   <= |(stat_d & mask_d);
      end
   end
endmodule

// File: rtl/dma_evt_irq.sv
module dma_evt_irq
   import dmairq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned ADDR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [NUM_CH-1:0] evt_btc,
   input  logic [NUM_CH-1:0] evt_chn,
   input  logic [NUM_CH-1:0] evt_err,
   output logic [31:0]       rdata,
   output logic              irq
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_nch
      $error("dma_evt_irq: NUM_CH must be between 1 and 8");
   end
   if (ADDR_W < 6) begin : g_bad_aw
      $error("dma_evt_irq: ADDR_W too small for register offsets");
   end

   localparam logic [ADDR_W-1:0] A_SETM = ADDR_W'(OFF_SETM);
   localparam logic [ADDR_W-1:0] A_CLRM = ADDR_W'(OFF_CLRM);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

   logic  set_en, clr_en, rd_mask, rd_stat;
   word_t mask_q, mask_d, stat_q, stat_d;

   assign set_en  = wr_en && (addr == A_SETM);
   assign clr_en  = wr_en && (addr == A_CLRM);
   assign rd_mask = rd_en && (addr == A_MASK);
   assign rd_stat = rd_en && (addr == A_STAT);

   evt_status_reg #(.NUM_CH(NUM_CH)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .evt_btc(evt_btc), .evt_chn(evt_chn), .evt_err(evt_err),
      .clr(rd_stat), .stat_q(stat_q), .stat_d(stat_d)
   );

   irq_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .set_en(set_en), .clr_en(clr_en), .wdata(wdata),
      .mask_q(mask_q), .mask_d(mask_d)
   );

   irq_read_out u_rd (
      .clk(clk), .rst_n(rst_n),
      .rd_mask(rd_mask), .rd_stat(rd_stat),
      .mask_q(mask_q), .stat_q(stat_q),
      .mask_d(mask_d), .stat_d(stat_d),
      .rdata(rdata), .irq(irq)
   );
endmodule

// File: rtl/dma_evt_irq_chk.sv
module dma_evt_irq_chk
   import dmairq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned ADDR_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic [NUM_CH-1:0] evt_btc,
   input logic [NUM_CH-1:0] evt_chn,
   input logic [NUM_CH-1:0] evt_err,
   input logic [31:0]       rdata,
   input logic              irq,
   input word_t             mask_q,
   input word_t             stat_q
);
   localparam word_t VALID = valid_bits(NUM_CH);

   word_t ev;
   logic  is_set, is_clr, is_rstat, is_rd;

   always_comb begin
      ev = '0;
      for (int unsigned c = 0; c < NUM_CH; c++) begin
         ev[c]      = evt_btc[c];
         ev[8 + c]  = evt_chn[c];
         ev[16 + c] = evt_err[c];
      end
   end

   assign is_set   = wr_en && (addr == ADDR_W'(OFF_SETM));
   assign is_clr   = wr_en && (addr == ADDR_W'(OFF_CLRM));
   assign is_rstat = rd_en && (addr == ADDR_W'(OFF_STAT));
   assign is_rd    = rd_en;

   assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(ev)) == $past(ev)));

   assert_set_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_set |=> ((mask_q & $past(wdata & VALID)) == $past(wdata & VALID)));

   assert_clr_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      is_clr |=> ((mask_q & $past(wdata & VALID)) == '0));

   assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      is_rstat |=> (stat_q == $past(ev)));

   assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(stat_q & mask_q));

   assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(is_set || is_clr) |=> $stable(mask_q));

   assert_stat_rdata_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_rstat |=> (rdata == $past(stat_q)));

   assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |=> (rdata == '0));
endmodule

bind dma_evt_irq dma_evt_irq_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_evt_irq_bench.sv
module dma_evt_irq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int AW  = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0]  addr = '0;
   logic [31:0]    wdata = '0;
   logic [NCH-1:0] evt_btc = '0, evt_chn = '0, evt_err = '0;
   logic [31:0]    rdata;
   logic           irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_evt_irq #(.NUM_CH(NCH), .ADDR_W(AW)) u_dma_evt_irq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .evt_btc(evt_btc), .evt_chn(evt_chn), .evt_err(evt_err),
      .rdata(rdata), .irq(irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic pulse(logic [NCH-1:0] b, logic [NCH-1:0] c, logic [NCH-1:0] e);
      @(negedge clk);
      evt_btc = b; evt_chn = c; evt_err = e;
      @(negedge clk);
      evt_btc = '0; evt_chn = '0; evt_err = '0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 rdata", rdata, 32'd0);
      reg_rd(8'h20, v); chk("R1 mask", v, 32'd0);
      reg_rd(8'h24, v); chk("R1 status", v, 32'd0);
   endtask

   task automatic t_latch();
      logic [31:0] v;
      pulse(8'h08, 8'h20, 8'h01);
      chk("R8 masked irq low", {31'd0, irq}, 32'd0);
      reg_rd(8'h24, v); chk("R2 status map", v, 32'h0001_2008);
      @(negedge clk);
      chk("R11 rdata idle", rdata, 32'd0);
      reg_rd(8'h24, v); chk("R5 cleared", v, 32'd0);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      reg_wr(8'h18, 32'h0001_0001);
      reg_rd(8'h20, v); chk("R3 set", v, 32'h0001_0001);
      reg_wr(8'h18, 32'h0);
      reg_rd(8'h20, v); chk("R3 zero write", v, 32'h0001_0001);
      reg_wr(8'h1C, 32'h1);
      reg_rd(8'h20, v); chk("R4 clear", v, 32'h0001_0000);
      reg_wr(8'h1C, 32'h0);
      reg_rd(8'h20, v); chk("R4 zero write", v, 32'h0001_0000);
      reg_wr(8'h18, 32'hFF00_0000);
      reg_rd(8'h20, v); chk("R9 upper bits", v, 32'h0001_0000);
      reg_wr(8'h20, 32'h00FF_FFFF);
      reg_rd(8'h20, v); chk("R9 mask addr write", v, 32'h0001_0000);
      reg_wr(8'h24, 32'h00FF_FFFF);
      reg_rd(8'h24, v); chk("R9 status addr write", v, 32'd0);
      reg_rd(8'h18, v); chk("R10 set reg read", v, 32'd0);
      reg_rd(8'h1C, v); chk("R10 clr reg read", v, 32'd0);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      pulse(8'h00, 8'h00, 8'h02);
      chk("R7 unmasked only", {31'd0, irq}, 32'd0);
      pulse(8'h00, 8'h00, 8'h01);
      chk("R7 irq rise", {31'd0, irq}, 32'd1);
      reg_rd(8'h24, v); chk("R5 status", v, 32'h0003_0000);
      chk("R7 irq fall", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_pending();
      logic [31:0] v;
      reg_wr(8'h1C, 32'h00FF_FFFF);
      pulse(8'h80, 8'h00, 8'h00);
      chk("R8 pending masked", {31'd0, irq}, 32'd0);
      reg_wr(8'h18, 32'h0000_0080);
      chk("R8 unmask raises", {31'd0, irq}, 32'd1);
      reg_rd(8'h24, v); chk("R8 status", v, 32'h0000_0080);
      chk("R7 cleared low", {31'd0, irq}, 32'd0);
      reg_wr(8'h1C, 32'h00FF_FFFF);
   endtask

   task automatic t_same_cycle();
      logic [31:0] v;
      pulse(8'h00, 8'h02, 8'h00);
      @(negedge clk);
      rd_en = 1'b1; addr = 8'h24; evt_btc = 8'h04;
      @(negedge clk);
      rd_en = 1'b0; evt_btc = '0;
      chk("R6 read excludes new", rdata, 32'h0000_0200);
      reg_rd(8'h24, v); chk("R6 new kept", v, 32'h0000_0004);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latch();
      t_mask();
      t_irq();
      t_pending();
      t_same_cycle();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule